// File: doc/BRIEF.md
# Ring-Oscillator Phase Quantizer Back-End

This block is the digital half of an oscillator-based converter. An odd-length ring oscillator whose frequency follows the analog input presents its stage outputs as a tap word. On every sample clock edge the block registers that word. It then compares the new oscillator state with the one from the previous sample and reports how far the ring has moved. Because the oscillator integrates the input and the block differences the quantized phase, the quantization error is shaped to first order. The signal itself passes with unit gain, and the block applies no other filtering.

Two variants are chosen by a parameter. In the fine variant, the code is the number of taps that changed state, found by XOR and population count. This count folds once the ring advances more than half a period per sample. In the extended variant, a free-running counter clocked by tap 0 counts whole oscillator periods. The block decodes the ring position from each captured word and combines the two, so the code is the exact number of stage transitions between samples.

Top module: `vco_phase_backend`

## Requirements
- R1: While `rst_n` is low at a clock edge, `code_vld` and `code` are both 0 after that edge.
- R2: After reset is released, `code_vld` is low after the first three edges. It is high after the fourth edge and after every later edge until the next reset.
- R3: Each tap word passes two sample-clock flops before use. The code presented after edge E describes the ring movement between the words present at edges E-3 and E-2.
- R4: With `COARSE_EN`=0, `code` equals the number of tap bits that differ between the two compared words. It lies in 0..N, and it is 0 when the ring has not moved.
- R5: With `COARSE_EN`=0, an advance of r transitions (taken modulo 2N) gives r when r ≤ N and 2N−r otherwise. A full period gives 0. For N=7, an advance of 8 gives 6.
- R6: With `COARSE_EN`=1, `code` equals the exact number of ring transitions between the compared words, provided tap 0 rises at most 2^COARSE_W−1 times in that interval. Ring state s (0..2N−1) drives tap k high when s<N and k<s, or when s≥N and k≥s−N. Tap 0 therefore rises on the move from state 0 to state 1.
- R7: With `COARSE_EN`=1, the result stays exact while the period counter wraps around its COARSE_W-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_taps | input | N_STAGES | Raw oscillator stage outputs, asynchronous to `clk` |
| code | output | CODE_W | Transition count for the latest sample |
| code_vld | output | 1 | High on each edge that produces a new code |

## Verification
The hardest cases to reach from the ports need the oscillator to move by many transitions within one sample. One such case is a move of exactly one period, which the fine variant folds to zero while the extended variant must report 2N. Another is the period counter wrapping between two samples. The bench models the ring as a single phase count that drives all taps. In the low half of each clock it steps that phase one transition at a time, every 10 ps, so tap 0 produces real rising edges. Long runs at large steps force repeated counter wraps, and single steps of N+1, 2N and 3N check folding.

// File: rtl/vco_qz_pkg.sv
// Package: shared types for the ring-oscillator phase quantizer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package vco_qz_pkg;

    // Warm-up progress after reset: counts captured samples until both
    // compared words are genuine.
    typedef enum logic [1:0] {
        WU_EMPTY = 2'd0,
        WU_ONE   = 2'd1,
        WU_TWO   = 2'd2,
        WU_LIVE  = 2'd3
    } warm_e;

endpackage

// File: rtl/vco_tap_sync.sv
// Module: two-flop capture stage on the sample clock for a W-bit word.
// Assumes the input is asynchronous; it adds two cycles of latency and
// clears synchronously on an active-low reset.
module vco_tap_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture the word and pass it through the second flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/vco_coarse_cnt.sv
// Module: free-running period counter clocked by one oscillator tap.
// Assumes the tap toggles while reset is applied if a cleared start is
// wanted; only differences of its value are used downstream. It emits a
// Gray-coded copy so one bit changes per increment across the crossing.
module vco_coarse_cnt #(
    parameter int W = 4
) (
    input  logic         tap_clk,
    input  logic         rst_n,
    output logic [W-1:0] gray_o
);

    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nxt;
    logic [W-1:0] gray_q;

    // Next binary count, wrapping modulo 2^W.
    always_comb begin
        bin_nxt = bin_q + W'(1);
    end

    // Count rising edges of the tap and register the Gray form.
    always_ff @(posedge tap_clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    assign gray_o = gray_q;

endmodule

// File: rtl/vco_code_core.sv
// Module: differencing core. Compares the captured ring word with the
// previous one and forms the output code, either as a popcount of the XOR
// (fine) or as an exact transition count using the period counter (coarse).
// Assumes N is odd, that word_i and gray_i were captured on the same edges,
// and that the ring only moves forward.
module vco_code_core
    import vco_qz_pkg::*;
#(
    parameter int N         = 7,
    parameter int COARSE_EN = 1,
    parameter int COARSE_W  = 4,
    parameter int CODE_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        word_i,
    input  logic [COARSE_W-1:0] gray_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                vld_o
);

    localparam int TWO_N  = 2 * N;
    localparam int POS_W  = $clog2(TWO_N);
    localparam int FINE_W = $clog2(N + 1);

    warm_e             wu_q;
    logic [N-1:0]      prev_q;
    logic [N-1:0]      diff;
    logic [FINE_W-1:0] ones;
    logic [CODE_W-1:0] code_nxt;
    logic [CODE_W-1:0] code_q;
    logic              vld_q;

    // Mark which taps changed and count them.
    always_comb begin
        diff = word_i ^ prev_q;
        ones = '0;
        for (int k = 0; k < N; k++) begin
            ones = ones + FINE_W'(diff[k]);
        end
    end

    // Step through warm-up until two real samples are held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wu_q <= WU_EMPTY;
        end else begin
            case (wu_q)
                WU_EMPTY: wu_q <= WU_ONE;
                WU_ONE:   wu_q <= WU_TWO;
                default:  wu_q <= WU_LIVE;
            endcase
        end
    end

    // Keep the previous captured ring word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= word_i;
        end
    end

    generate
        if (COARSE_EN != 0) begin : g_coarse
            logic [COARSE_W-1:0] cbin_now;
            logic [COARSE_W-1:0] cprev_q;
            logic [COARSE_W-1:0] dc;
            logic [POS_W-1:0]    pos_cur;
            logic [POS_W-1:0]    pos_prev;
            int                  fold;

            // Ring position measured from the tap-0 rising transition.
            function automatic logic [POS_W-1:0] ring_pos(input logic [N-1:0] w);
                int cnt;
                int st;
                cnt = 0;
                for (int k = 0; k < N; k++) begin
                    cnt += int'(w[k]);
                end
                st = w[N-1] ? (TWO_N - cnt) : cnt;
                return (st == 0) ? POS_W'(TWO_N - 1) : POS_W'(st - 1);
            endfunction

            // Gray to binary conversion of the synchronized period count.
            always_comb begin
                cbin_now[COARSE_W-1] = gray_i[COARSE_W-1];
                for (int k = COARSE_W - 2; k >= 0; k--) begin
                    cbin_now[k] = cbin_now[k+1] ^ gray_i[k];
                end
            end

            // Exact transitions: whole periods plus position difference.
            always_comb begin
                pos_cur  = ring_pos(word_i);
                pos_prev = ring_pos(prev_q);
                dc       = cbin_now - cprev_q;
                code_nxt = CODE_W'(dc) * CODE_W'(TWO_N)
                         + CODE_W'(pos_cur) - CODE_W'(pos_prev);
                fold     = (int'(pos_cur) - int'(pos_prev) + TWO_N) % TWO_N;
                if (fold > N) begin
                    fold = TWO_N - fold;
                end
            end

            // Hold the period count of the previous sample.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cprev_q <= '0;
                end else begin
                    cprev_q <= cbin_now;
                end
            end

            AST_FINE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
                (wu_q == WU_LIVE) |-> (int'(ones) == fold)); // R6

            AST_STILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (wu_q == WU_LIVE && word_i == prev_q && cbin_now == cprev_q)
                |=> (code_q == '0)); // R4
        end else begin : g_fine
            // Fine code is the popcount of the XOR.
            always_comb begin
                code_nxt = CODE_W'(ones);
            end

            AST_FINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q |-> (code_q <= CODE_W'(N))); // R4

            AST_STILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (wu_q == WU_LIVE && word_i == prev_q) |=> (code_q == '0)); // R4
        end
    endgenerate

    // Register the code and its valid flag once warm-up is done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= (wu_q == WU_LIVE);
            if (wu_q == WU_LIVE) begin
                code_q <= code_nxt;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!vld_q && code_q == '0)); // R1

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> vld_q); // R2

    AST_WARM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wu_q != WU_LIVE) |=> !vld_q); // R2

    assign code_o = code_q;
    assign vld_o  = vld_q;

endmodule

// File: rtl/vco_phase_backend.sv
// Module: top of the ring-oscillator phase quantizer back-end. Captures the
// taps on the sample clock, optionally counts oscillator periods on tap 0
// and hands both to the differencing core.
// Assumes N_STAGES is odd and the taps follow a forward-running ring.
module vco_phase_backend #(
    parameter int  N_STAGES  = 7,
    parameter int  COARSE_EN = 1,
    parameter int  COARSE_W  = 4,
    localparam int CODE_W    = (COARSE_EN != 0)
                             ? (COARSE_W + $clog2(2 * N_STAGES))
                             : $clog2(N_STAGES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] ring_taps,
    output logic [CODE_W-1:0]   code,
    output logic                code_vld
);

    logic [N_STAGES-1:0] word_s;
    logic [COARSE_W-1:0] gray_s;

    vco_tap_sync #(.W(N_STAGES)) u_tap_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ring_taps),
        .q_o   (word_s)
    );

    generate
        if (COARSE_EN != 0) begin : g_periods
            logic [COARSE_W-1:0] gray_raw;

            vco_coarse_cnt #(.W(COARSE_W)) u_coarse (
                .tap_clk (ring_taps[0]),
                .rst_n   (rst_n),
                .gray_o  (gray_raw)
            );

            vco_tap_sync #(.W(COARSE_W)) u_gray_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (gray_raw),
                .q_o   (gray_s)
            );
        end else begin : g_no_periods
            assign gray_s = '0;
        end
    endgenerate

    vco_code_core #(
        .N         (N_STAGES),
        .COARSE_EN (COARSE_EN),
        .COARSE_W  (COARSE_W),
        .CODE_W    (CODE_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (word_s),
        .gray_i (gray_s),
        .code_o (code),
        .vld_o  (code_vld)
    );

endmodule

// File: tb/vco_phase_backend_test.sv
`timescale 1ns/1ps
module vco_phase_backend_test;

    localparam int N      = 7;
    localparam int TWO_N  = 14;
    localparam int CODE_W = 8;
    localparam int FINE_W = 3;
    localparam int HIST   = 2048;
    localparam int ADV_TAB [16] = '{0, 1, 2, 5, 7, 8, 13, 14, 15, 27, 40, 99, 150, 210, 3, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      taps;
    logic [CODE_W-1:0] code_c;
    logic              vld_c;
    logic [FINE_W-1:0] code_f;
    logic              vld_f;

    int    ph = 0;
    int    ecnt = 0;
    int    hi = 0;
    int    checks = 0;
    int    fails = 0;
    int    ph_hist [HIST];
    string tag = "start";

    always #2.5 clk = ~clk;

    // Ring model: state s drives tap k high per the R6 encoding.
    function automatic logic [N-1:0] ring_word(input int p);
        logic [N-1:0] w;
        int s;
        s = p % TWO_N;
        for (int k = 0; k < N; k++) begin
            w[k] = (s < N) ? (k < s) : !(k < s - N);
        end
        return w;
    endfunction

    assign taps = ring_word(ph);

    vco_phase_backend uut (
        .clk (clk), .rst_n (rst_n), .ring_taps (taps), .code (code_c), .code_vld (vld_c)
    );

    vco_phase_backend #(.COARSE_EN(0)) uut_fine (
        .clk (clk), .rst_n (rst_n), .ring_taps (taps), .code (code_f), .code_vld (vld_f)
    );

    // Record the ring phase at every edge and count edges out of reset.
    always @(posedge clk) begin
        if (ecnt < HIST) ph_hist[ecnt] = ph;
        ecnt = ecnt + 1;
        hi = rst_n ? hi + 1 : 0;
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // At a falling edge: check outputs, then move the ring by adv transitions.
    task automatic tick(input int adv);
        int d;
        int r;
        @(negedge clk);
        if (hi == 0) begin
            chk("R1 coarse valid", int'(vld_c), 0);
            chk("R1 coarse code", int'(code_c), 0);
            chk("R1 fine valid", int'(vld_f), 0);
            chk("R1 fine code", int'(code_f), 0);
        end else begin
            chk("R2 coarse valid", int'(vld_c), (hi >= 4) ? 1 : 0);
            chk("R2 fine valid", int'(vld_f), (hi >= 4) ? 1 : 0);
            if (hi >= 4 && ecnt >= 4 && ecnt <= HIST) begin
                d = ph_hist[ecnt-3] - ph_hist[ecnt-4];
                r = d % TWO_N;
                chk({"R3 R6 R7 coarse ", tag}, int'(code_c), d);
                chk({"R3 R4 R5 fine ", tag}, int'(code_f), (r <= N) ? r : TWO_N - r);
            end
        end
        for (int i = 0; i < adv; i++) begin
            #0.01;
            ph = ph + 1;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) tick(1);
        rst_n = 1'b1;
        tag = "table";
        for (int i = 0; i < 16; i++) tick(ADV_TAB[i]);
        tag = "R5 folding";
        tick(14); tick(8); tick(7); tick(21); tick(0); tick(0); tick(0);
        tag = "R7 wrap";
        repeat (30) tick(200);
        tick(0); tick(0);
        tag = "R4 still";
        repeat (5) tick(0);
        tag = "R1 R2 re-reset";
        rst_n = 1'b0;
        tick(3); tick(3); tick(3);
        rst_n = 1'b1;
        repeat (8) tick(5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule